// File: doc/BRIEF.md
# Byte-Serial SPI Port with Master Fault Detection

This block is a single-byte SPI port that runs as either the clock-driving master or the clock-following slave. A small register file sets it up. It has a control byte, a status byte and a data byte, all reached through a two-bit address with separate write and read strobes. In master mode a data write starts an exchange. The port drives SCK and MOSI and samples MISO. In slave mode the port drives MISO only while its select input is low, and it follows the SCK edges it sees on the pin.

The control byte sets clock polarity, clock phase and a master bit rate. The bit rate comes from a two-bit code and a bypass bit that removes one divide-by-two stage. Three status events can raise the interrupt output when it is enabled: byte complete, overrun and master fault. A master fault happens when another device pulls the select input low while the port is master. Hardware then drops the port out of both enable and master.

In slave mode the SCK and select pins pass through a two-stage synchronizer. The master's SCK half-period must therefore be at least four system clocks for an exchange with a slave port, which means a divisor of 8 or more.

Top module: `spi_port`

## Requirements
- R1: After reset the control byte (address 0) and status byte (address 1) read 0x00, and sck_oe, mosi_oe, miso_oe and irq are all low.
- R2: The control byte reads back as written, with bit 7 interrupt enable, bit 6 port enable, bit 5 divider bypass, bit 4 master, bit 3 clock polarity, bit 2 clock phase and bits 1:0 the rate code. While bit 6 is 0, no pin output enable is set.
- R3: An enabled master drives sck_oe and mosi_oe high and miso_oe low. An enabled slave whose select input is low drives only miso_oe high.
- R4: An enabled master that is not transferring holds SCK at the polarity bit: low for 0, high for 1.
- R5: Data moves MSB first. With phase 0 each bit is captured on the first SCK edge of its bit period, and with phase 1 on the second edge. A master port and a slave port with the same polarity and phase exchange bytes correctly in all four modes.
- R6: The master SCK period is 2^(2 + rate + (1 - bypass)) system clocks. This gives 4 for rate 00 with bypass 1, 8 for rate 00 with bypass 0, and doubles with each rate step up to 64.
- R7: The rate code and the bypass bit have no effect on a slave port, which follows the SCK pin.
- R8: On each completed byte, status bit 7 (done) is set and the received byte is placed in the data register (address 2). irq equals interrupt-enable AND (done OR overrun OR fault).
- R9: If a byte completes while done is still set, status bit 6 (overrun) is set and the data register keeps the earlier byte.
- R10: A status read followed by a data-register read or write clears done, overrun and fault. A data access with no status read before it clears nothing.
- R11: While the port is an enabled master, a low select input sets status bit 5 (fault) and clears the port-enable and master bits. All pin output enables then drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (used for the flag-clear sequence) |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Read data for addr, combinational |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | SCK pin level, used as slave |
| sck_o | output | 1 | SCK drive value, used as master |
| sck_oe | output | 1 | SCK output enable |
| mosi_i | input | 1 | MOSI pin level, sampled as slave |
| mosi_o | output | 1 | MOSI drive value |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO pin level, sampled as master |
| miso_o | output | 1 | MISO drive value |
| miso_oe | output | 1 | MISO output enable |
| ss_n_i | input | 1 | Active-low select input |

## Verification
A bit counter that slips, or a wrong capture/launch choice, shows up as a corrupted byte in the data register of one of the two ports. It appears at the end of the first exchange, which is sixteen SCK edges after the master write. A baud counter that is off shows as a wrong spacing of SCK toggles within the first bit period. A wrong idle level shows on sck_o as soon as the master is enabled. Bad flag logic shows in the next status read, or on irq one cycle after the event. A missed fault shows up about three cycles after the select input falls: the output enables and the control readback keep their old values.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    localparam int BYTE_W = 8;
    localparam int RATE_W = 2;
    // largest half period is 2^(1 + max rate + 1)
    localparam int MAX_SH = 1 + (2 ** RATE_W - 1) + 1;
    localparam int CNT_W  = MAX_SH + 1;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;

    typedef struct packed {
        logic              irq_en;
        logic              enable;
        logic              div_bypass;
        logic              master;
        logic              cpol;
        logic              cpha;
        logic [RATE_W-1:0] rate;
    } ctrl_t;

    typedef struct packed {
        logic       done;
        logic       ovr;
        logic       fault;
        logic [4:0] rsvd;
    } stat_t;

    typedef enum logic [1:0] {
        ROLE_OFF,
        ROLE_MASTER,
        ROLE_SLAVE
    } role_e;

    // system clocks per SCK half period
    function automatic logic [CNT_W-1:0] half_period(input logic [RATE_W-1:0] rate,
                                                     input logic bypass);
        int sh;
        sh = 1 + int'(rate) + (bypass ? 0 : 1);
        return CNT_W'(1 << sh);
    endfunction

endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
    parameter int               WIDTH     = 2,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= RESET_VAL;
                else     stg[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= RESET_VAL;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_port_baud.sv
module spi_port_baud #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] half,
    output logic             tick
);
    logic [CNT_W-1:0] cnt;

    assign tick = run && (cnt == half - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

    // R6: half period is at least two clocks, so ticks never touch
    a_r6_tick_gap: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/spi_port_shift.sv
module spi_port_shift #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             abort,
    input  logic             load,
    input  logic [WIDTH-1:0] load_data,
    input  logic             edge_stb,
    input  logic             cpha,
    input  logic             in_bit,
    output logic             out_bit,
    output logic             mid,
    output logic             done_stb,
    output logic [WIDTH-1:0] rx_word
);
    localparam int EDGES = 2 * WIDTH;
    localparam int EW    = $clog2(EDGES);
    localparam logic [EW-1:0] LAST = EW'(EDGES - 1);

    logic [EW-1:0]    ecnt;
    logic [WIDTH-1:0] tx_sr;
    logic [WIDTH-1:0] rx_sr;
    logic             capture;
    logic             launch;

    // phase 0 samples on even edges, phase 1 on odd edges
    assign capture  = cpha ? ecnt[0] : !ecnt[0];
    // phase 1 already shows the MSB before its first edge
    assign launch   = !capture && !(cpha && (ecnt == '0));
    assign done_stb = edge_stb && !abort && !load && (ecnt == LAST);
    assign rx_word  = capture ? {rx_sr[WIDTH-2:0], in_bit} : rx_sr;
    assign out_bit  = tx_sr[WIDTH-1];
    assign mid      = (ecnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ecnt  <= '0;
            tx_sr <= '0;
            rx_sr <= '0;
        end else if (load) begin
            tx_sr <= load_data;
            ecnt  <= '0;
        end else if (abort) begin
            ecnt <= '0;
        end else if (edge_stb) begin
            ecnt <= (ecnt == LAST) ? '0 : ecnt + 1'b1;
            if (capture) rx_sr <= {rx_sr[WIDTH-2:0], in_bit};
            if (launch)  tx_sr <= {tx_sr[WIDTH-2:0], 1'b0};
        end
    end

    // R5: a byte ends after exactly 2*WIDTH edges and the counter restarts
    a_r5_byte_wrap: assert property (@(posedge clk) disable iff (rst)
        done_stb |=> (ecnt == '0));
endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              irq,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              mosi_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              ss_n_i
);
    ctrl_t             ctrl_q;
    stat_t             stat_q;
    logic [BYTE_W-1:0] rx_q;
    logic              stat_armed;
    logic              m_busy;
    logic              sck_lvl;
    logic              sck_prev;
    logic [1:0]        pins_s;
    logic              ss_s, sck_s;
    role_e             role;
    logic              slave_sel, fault_now, tick, edge_stb, abort, in_bit;
    logic              out_bit, mid, done_stb, load, start, data_acc, clr;
    logic [BYTE_W-1:0] rx_word;

    spi_port_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(2'b10)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ss_n_i, sck_i}),
        .q   (pins_s)
    );
    assign ss_s  = pins_s[1];
    assign sck_s = pins_s[0];

    always_ff @(posedge clk) begin
        if (rst) sck_prev <= 1'b0;
        else     sck_prev <= sck_s;
    end

    always_comb begin
        if (!ctrl_q.enable)     role = ROLE_OFF;
        else if (ctrl_q.master) role = ROLE_MASTER;
        else                    role = ROLE_SLAVE;
    end

    assign slave_sel = (role == ROLE_SLAVE) && !ss_s;
    assign fault_now = (role == ROLE_MASTER) && !ss_s;

    spi_port_baud #(.CNT_W(CNT_W)) u_baud (
        .clk  (clk),
        .rst  (rst),
        .run  (m_busy),
        .half (half_period(ctrl_q.rate, ctrl_q.div_bypass)),
        .tick (tick)
    );

    assign edge_stb = (role == ROLE_MASTER) ? (m_busy && tick)
                                            : (slave_sel && (sck_s ^ sck_prev));
    assign abort    = (role == ROLE_OFF) || ((role == ROLE_SLAVE) && ss_s);
    assign in_bit   = (role == ROLE_MASTER) ? miso_i : mosi_i;
    assign data_acc = (wr_en || rd_en) && (addr == A_DATA);
    assign load     = wr_en && (addr == A_DATA) && !m_busy && !mid;
    assign start    = load && (role == ROLE_MASTER);
    assign clr      = stat_armed && data_acc;

    spi_port_shift #(.WIDTH(BYTE_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .abort     (abort),
        .load      (load),
        .load_data (wdata),
        .edge_stb  (edge_stb),
        .cpha      (ctrl_q.cpha),
        .in_bit    (in_bit),
        .out_bit   (out_bit),
        .mid       (mid),
        .done_stb  (done_stb),
        .rx_word   (rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            stat_q     <= '0;
            rx_q       <= '0;
            stat_armed <= 1'b0;
            m_busy     <= 1'b0;
            sck_lvl    <= 1'b0;
        end else begin
            if (start)                                m_busy <= 1'b1;
            else if (done_stb || role != ROLE_MASTER) m_busy <= 1'b0;

            if (start || role != ROLE_MASTER) sck_lvl <= 1'b0;
            else if (edge_stb)                sck_lvl <= ~sck_lvl;

            if (wr_en && addr == A_CTRL) ctrl_q <= ctrl_t'(wdata);
            if (fault_now) begin
                ctrl_q.enable <= 1'b0;
                ctrl_q.master <= 1'b0;
            end

            if (rd_en && addr == A_STAT) stat_armed <= 1'b1;
            else if (data_acc)           stat_armed <= 1'b0;

            if (clr) begin
                stat_q.done  <= 1'b0;
                stat_q.ovr   <= 1'b0;
                stat_q.fault <= 1'b0;
            end
            if (done_stb) begin
                if (stat_q.done && !clr) begin
                    stat_q.ovr <= 1'b1;
                end else begin
                    stat_q.done <= 1'b1;
                    rx_q        <= rx_word;
                end
            end
            if (fault_now) stat_q.fault <= 1'b1;
        end
    end

    always_comb begin
        case (addr)
            A_CTRL:  rdata = ctrl_q;
            A_STAT:  rdata = stat_q;
            A_DATA:  rdata = rx_q;
            default: rdata = '0;
        endcase
    end

    assign irq     = ctrl_q.irq_en && (stat_q.done || stat_q.ovr || stat_q.fault);
    assign sck_oe  = (role == ROLE_MASTER);
    assign sck_o   = ctrl_q.cpol ^ sck_lvl;
    assign mosi_oe = (role == ROLE_MASTER);
    assign mosi_o  = (role == ROLE_MASTER) ? out_bit : 1'b0;
    assign miso_oe = slave_sel;
    assign miso_o  = slave_sel ? out_bit : 1'b0;

    // R11: a master that sees select low leaves master and enable next cycle
    a_r11_fault_drop: assert property (@(posedge clk) disable iff (rst)
        fault_now |=> (!ctrl_q.enable && !ctrl_q.master && stat_q.fault));

    // R4: an idle master rests SCK at the polarity level
    a_r4_idle_level: assert property (@(posedge clk) disable iff (rst)
        (role == ROLE_MASTER && !m_busy) |-> (sck_o == ctrl_q.cpol));

    // R9: a byte landing on an unread one raises overrun and keeps the old data
    a_r9_ovr_keep: assert property (@(posedge clk) disable iff (rst)
        (done_stb && stat_q.done && !clr) |=> (stat_q.ovr && $stable(rx_q)));

    // R10: the clear sequence drops all three flags unless a new event lands
    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        (clr && !done_stb && !fault_now) |=> (!stat_q.done && !stat_q.ovr && !stat_q.fault));
endmodule

// File: tb/spi_port_bench.sv
module spi_port_bench;
    import spi_port_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst;
    logic [1:0] m_addr, s_addr;
    logic       m_wr, m_rd, s_wr, s_rd;
    logic [7:0] m_wdata, s_wdata, m_rdata, s_rdata;
    logic       m_irq, s_irq;
    logic       m_sck_o, m_sck_oe, m_mosi_o, m_mosi_oe, m_miso_o, m_miso_oe;
    logic       s_sck_o, s_sck_oe, s_mosi_o, s_mosi_oe, s_miso_o, s_miso_oe;
    logic       m_ss_n, s_ss_n, sck_pull, miso_pull;
    logic       sck_bus, mosi_bus, miso_bus;

    assign sck_bus  = m_sck_oe  ? m_sck_o  : sck_pull;
    assign mosi_bus = m_mosi_oe ? m_mosi_o : 1'b0;
    assign miso_bus = s_miso_oe ? s_miso_o : miso_pull;

    spi_port u_spi_port (
        .clk(clk), .rst(rst), .addr(m_addr), .wr_en(m_wr), .rd_en(m_rd),
        .wdata(m_wdata), .rdata(m_rdata), .irq(m_irq),
        .sck_i(sck_bus), .sck_o(m_sck_o), .sck_oe(m_sck_oe),
        .mosi_i(mosi_bus), .mosi_o(m_mosi_o), .mosi_oe(m_mosi_oe),
        .miso_i(miso_bus), .miso_o(m_miso_o), .miso_oe(m_miso_oe),
        .ss_n_i(m_ss_n)
    );

    spi_port u_slave (
        .clk(clk), .rst(rst), .addr(s_addr), .wr_en(s_wr), .rd_en(s_rd),
        .wdata(s_wdata), .rdata(s_rdata), .irq(s_irq),
        .sck_i(sck_bus), .sck_o(s_sck_o), .sck_oe(s_sck_oe),
        .mosi_i(mosi_bus), .mosi_o(s_mosi_o), .mosi_oe(s_mosi_oe),
        .miso_i(miso_bus), .miso_o(s_miso_o), .miso_oe(s_miso_oe),
        .ss_n_i(s_ss_n)
    );

    int checks = 0;
    int errors = 0;

    // {cpol, cpha, rate[1:0], bypass, master byte, slave byte}; divisor >= 8
    localparam logic [20:0] VEC [8] = '{
        {1'b0, 1'b0, 2'b00, 1'b0, 8'hA5, 8'h3C},
        {1'b0, 1'b1, 2'b01, 1'b1, 8'h81, 8'h7E},
        {1'b1, 1'b0, 2'b00, 1'b0, 8'h0F, 8'hF0},
        {1'b1, 1'b1, 2'b10, 1'b1, 8'h55, 8'hAA},
        {1'b0, 1'b0, 2'b11, 1'b1, 8'hC3, 8'h18},
        {1'b0, 1'b1, 2'b00, 1'b0, 8'h01, 8'h80},
        {1'b1, 1'b0, 2'b01, 1'b0, 8'hFF, 8'h00},
        {1'b1, 1'b1, 2'b00, 1'b0, 8'h6D, 8'hB2}
    };
    // {rate[1:0], bypass} and the SCK period expected for it
    localparam logic [2:0] BSEL [5] = '{3'b001, 3'b000, 3'b010, 3'b111, 3'b110};
    localparam int         BPER [5] = '{4, 8, 16, 32, 64};

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input bit dev, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        if (dev) begin s_addr = a; s_wdata = d; s_wr = 1'b1; end
        else     begin m_addr = a; m_wdata = d; m_wr = 1'b1; end
        @(negedge clk);
        m_wr = 1'b0;
        s_wr = 1'b0;
    endtask

    task automatic rd(input bit dev, input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        if (dev) begin s_addr = a; s_rd = 1'b1; end
        else     begin m_addr = a; m_rd = 1'b1; end
        #1;
        d = dev ? s_rdata : m_rdata;
        @(negedge clk);
        m_rd = 1'b0;
        s_rd = 1'b0;
    endtask

    task automatic wait_irq(input bit dev, input string req);
        bit seen = 1'b0;
        for (int k = 0; k < 3000 && !seen; k++) begin
            @(negedge clk);
            seen = dev ? s_irq : m_irq;
        end
        check(req, {7'd0, seen}, 8'h01);
    endtask

    task automatic clear_flags(input bit dev);
        logic [7:0] tmp;
        rd(dev, A_STAT, tmp);
        rd(dev, A_DATA, tmp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] r;
        rst = 1'b1;
        m_addr = '0; s_addr = '0; m_wr = 0; m_rd = 0; s_wr = 0; s_rd = 0;
        m_wdata = '0; s_wdata = '0;
        m_ss_n = 1'b1; s_ss_n = 1'b1; sck_pull = 1'b0; miso_pull = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(0, A_CTRL, r); check("R1 ctrl", r, 8'h00);
        rd(0, A_STAT, r); check("R1 stat", r, 8'h00);
        check("R1 pins", {4'd0, m_sck_oe, m_mosi_oe, m_miso_oe, m_irq}, 8'h00);

        // R2 readback with port disabled
        wr(0, A_CTRL, 8'h2D);
        rd(0, A_CTRL, r); check("R2 ctrl readback", r, 8'h2D);
        check("R2 disabled no drive", {5'd0, m_sck_oe, m_mosi_oe, m_miso_oe}, 8'h00);
        wr(0, A_CTRL, 8'h00);

        // R5 / R7 / R8 loopback in all four modes
        for (int i = 0; i < 8; i++) begin
            logic       cpol, cpha, byp;
            logic [1:0] rate;
            logic [7:0] mtx, stx;
            {cpol, cpha, rate, byp, mtx, stx} = VEC[i];
            wr(0, A_CTRL, 8'h00);
            wr(1, A_CTRL, 8'h00);
            s_ss_n = 1'b1;
            sck_pull = cpol;
            repeat (4) @(negedge clk);
            wr(1, A_CTRL, {1'b1, 1'b1, ~byp, 1'b0, cpol, cpha, ~rate});
            wr(1, A_DATA, stx);
            s_ss_n = 1'b0;
            repeat (4) @(negedge clk);
            if (i == 0)
                check("R3 slave drive", {5'd0, s_sck_oe, s_mosi_oe, s_miso_oe}, 8'h01);
            wr(0, A_CTRL, {1'b1, 1'b1, byp, 1'b1, cpol, cpha, rate});
            check("R4 idle sck", {7'd0, m_sck_o}, {7'd0, cpol});
            if (i == 0)
                check("R3 master drive", {5'd0, m_sck_oe, m_mosi_oe, m_miso_oe}, 8'h06);
            wr(0, A_DATA, mtx);
            wait_irq(0, "R8 master irq");
            wait_irq(1, "R8 slave irq");
            rd(0, A_STAT, r); check("R8 master done", r, 8'h80);
            rd(0, A_DATA, r); check("R5 master rx", r, stx);
            rd(1, A_STAT, r); check("R8 slave done", r, 8'h80);
            rd(1, A_DATA, r); check("R7 slave rx", r, mtx);
            check("R10 irq cleared", {6'd0, m_irq, s_irq}, 8'h00);
            s_ss_n = 1'b1;
        end

        // R6 master bit rate
        wr(0, A_CTRL, 8'h00);
        sck_pull = 1'b0;
        for (int b = 0; b < 5; b++) begin
            int   t1, t2, n;
            logic prev;
            wr(0, A_CTRL, {1'b0, 1'b1, BSEL[b][0], 1'b1, 1'b0, 1'b0, BSEL[b][2:1]});
            wr(0, A_DATA, 8'h5A);
            prev = m_sck_o; t1 = -1; t2 = -1; n = 0;
            for (int k = 0; k < 200 && t2 < 0; k++) begin
                @(negedge clk);
                n++;
                if (m_sck_o != prev) begin
                    prev = m_sck_o;
                    if (t1 < 0) t1 = n; else t2 = n;
                end
            end
            check("R6 sck period", 8'(2 * (t2 - t1)), 8'(BPER[b]));
            repeat (BPER[b] * 8 + 10) @(negedge clk);
            clear_flags(0);
        end

        // R8 masked irq, R9 overrun, R10 clear sequence
        wr(0, A_CTRL, 8'h50);
        miso_pull = 1'b1;
        wr(0, A_DATA, 8'h11);
        repeat (80) @(negedge clk);
        check("R8 irq masked", {7'd0, m_irq}, 8'h00);
        miso_pull = 1'b0;
        wr(0, A_DATA, 8'h22);
        repeat (80) @(negedge clk);
        rd(0, A_STAT, r); check("R9 overrun flag", r, 8'hC0);
        rd(0, A_DATA, r); check("R9 data kept", r, 8'hFF);
        rd(0, A_STAT, r); check("R10 flags cleared", r, 8'h00);
        wr(0, A_DATA, 8'h33);
        repeat (80) @(negedge clk);
        rd(0, A_DATA, r); check("R10 unarmed read data", r, 8'h00);
        rd(0, A_STAT, r); check("R10 unarmed no clear", r, 8'h80);
        rd(0, A_DATA, r);
        wr(0, A_DATA, 8'h44);
        repeat (80) @(negedge clk);
        wr(0, A_CTRL, 8'hD0);
        check("R8 irq on done", {7'd0, m_irq}, 8'h01);
        clear_flags(0);
        check("R8 irq after clear", {7'd0, m_irq}, 8'h00);

        // R11 master fault
        check("R11 master drives", {7'd0, m_sck_oe}, 8'h01);
        m_ss_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R11 fault irq", {7'd0, m_irq}, 8'h01);
        check("R11 pins released", {5'd0, m_sck_oe, m_mosi_oe, m_miso_oe}, 8'h00);
        rd(0, A_CTRL, r); check("R11 ctrl cleared", r, 8'h80);
        rd(0, A_STAT, r); check("R11 fault flag", r, 8'h20);
        m_ss_n = 1'b1;
        rd(0, A_DATA, r);
        rd(0, A_STAT, r); check("R10 fault cleared", r, 8'h00);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule